// File: doc/BRIEF.md
# Two-User Message Box

The message box lets two agents on one chip, called user A and user B, pass 32-bit words to each other. It has eight channels. Each channel owns a four-word first-in first-out buffer, and each buffer carries data in one direction only. Either user may set that direction. Each user has its own register port made of a request strobe, a write flag, a byte address and write data. Read data comes back one cycle after the request. Each user also has its own level interrupt line.

A sender writes words into a channel's data register, and the receiver reads them back out of the same register. A receive status bit rises while the receiver's buffer holds data. The receiver can clear that bit only once it has drained the buffer. Because each user can read the other user's status, the sender treats a cleared remote receive bit as the acknowledgement of its message. A transmit status bit tells the sender that there is room for another word.

Top module: `msg_box`

## Requirements
- R1: A write by the sending user to the data register at byte address 0x180+4n queues a word in channel n. A read by the receiving user at that address returns the oldest word and removes it. Read data appears on the user's rdata port one cycle after the request. Words leave in the order they were written.
- R2: Each buffer holds 4 words. Bit 0 of the word at 0x100+4n is 1 exactly when channel n holds 4 words. The word at 0x140+4n reports the number of queued words (0 to 4). A write to a full buffer is discarded.
- R3: A receiver read from an empty channel returns zero and leaves the count at zero. A sender read of the data register returns zero and removes nothing. A receiver write to the data register is discarded.
- R4: The direction word for channel n is at byte address 4*(n/4). Reading it shows bit 4+8*(n%4) set if the reader sends on channel n, and bit 8*(n%4) set if the reader receives on it. A write with the send bit set makes the writer the sender. A write with only the receive bit set makes the writer the receiver. A write with neither bit set leaves the direction unchanged. When both users write in the same cycle, user A wins.
- R5: In a user's interrupt status and enable words, bit 2n belongs to channel n receive and bit 2n+1 to channel n transmit. The receive bit becomes set while the user receives on channel n and that buffer is not empty.
- R6: Writing 1 to a receive bit of the local status word (0x70) clears it only if that channel's buffer is empty at that clock edge. While the buffer is non-empty the clear has no effect.
- R7: A transmit status bit is 1 while the user sends on that channel and the buffer is not full, and 0 otherwise. Writes to it have no effect.
- R8: Byte address 0x60 is the user's own read/write interrupt enable, and 0x70 is its own status. Address 0x40 returns the other user's enable and 0x50 returns the other user's status. Both of these are read-only, and writes to them are ignored.
- R9: A user's irq output is a register that is high when any bit of that user's status AND enable was set one cycle earlier.
- R10: After reset all buffers are empty, all enables are zero, no receive bit is set and every channel carries words from A to B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_req | input | 1 | User A access strobe |
| a_we | input | 1 | User A write (1) or read (0) |
| a_addr | input | AW (10) | User A byte address |
| a_wdata | input | DW (32) | User A write data |
| a_rdata | output | DW (32) | User A read data, one cycle after a read |
| a_irq | output | 1 | User A level interrupt |
| b_req | input | 1 | User B access strobe |
| b_we | input | 1 | User B write (1) or read (0) |
| b_addr | input | AW (10) | User B byte address |
| b_wdata | input | DW (32) | User B write data |
| b_rdata | output | DW (32) | User B read data, one cycle after a read |
| b_irq | output | 1 | User B level interrupt |

## Verification
The assertions assume that reset is held for at least one edge before any access. They also assume that a buffer's count only moves through the push and pop strobes derived from the two ports, so a receive bit whose buffer is non-empty must survive to the next edge. The stimulus keeps to word-aligned addresses and uses one user per access, except in one deliberate cycle where A pops and B pushes on the same channel. The direction of channel 6 is changed only while that channel is empty, so the sticky receive checks never see a buffer switch owners with words still inside.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Word (address/4) indices of the register regions.
  localparam int W_RMT_EN = 16;  // 0x40 other user's enable (read only)
  localparam int W_RMT_ST = 20;  // 0x50 other user's status (read only)
  localparam int W_LOC_EN = 24;  // 0x60 own enable
  localparam int W_LOC_ST = 28;  // 0x70 own status, receive bits W1C
  localparam int W_FSTAT  = 64;  // 0x100 + 4n, bit 0 = full
  localparam int W_MSTAT  = 80;  // 0x140 + 4n, queued word count
  localparam int W_DATA   = 96;  // 0x180 + 4n, push / pop port
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;   // push judged on the pre-edge level
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr];
  assign count_o = cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // storage without reset so it maps to memory
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R2: the count never exceeds the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R2: a push into a full buffer without a pop leaves the count alone
  p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (full_o && push_i && !pop_i) |=> $stable(cnt));

  // R3: a pop from an empty buffer without a push keeps it empty
  p_empty_pop_r3: assert property (@(posedge clk) disable iff (rst)
    (empty_o && pop_i && !push_i) |=> (cnt == '0));
endmodule

// File: rtl/mbox_user.sv
module mbox_user
  import mbox_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DW    = 32,
  parameter int AW    = 10,
  parameter int CW    = 3,
  parameter int SW    = 2 * NCH
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [AW-3:0]            wd_i,
  input  logic [SW-1:0]            wbits_i,
  input  logic [NCH-1:0]           snd_i,
  input  logic [NCH-1:0]           full_i,
  input  logic [NCH-1:0]           empty_i,
  input  logic [NCH-1:0][CW-1:0]   cnt_i,
  input  logic [NCH-1:0][DW-1:0]   head_i,
  input  logic [SW-1:0]            oth_stat_i,
  input  logic [SW-1:0]            oth_en_i,
  output logic [SW-1:0]            stat_o,
  output logic [SW-1:0]            en_o,
  output logic [DW-1:0]            rdata_o,
  output logic                     irq_o
);
  logic [NCH-1:0] rx_q, tx_q, clr;
  logic [SW-1:0]  en_q;
  logic [DW-1:0]  rd_val, rdata_q;
  logic           irq_q;
  int             w;

  assign w = int'(wd_i);

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      stat_o[2*n]   = rx_q[n];
      stat_o[2*n+1] = tx_q[n];
      clr[n] = req_i && we_i && (w == W_LOC_ST) && wbits_i[2*n];
    end
  end

  always_comb begin
    rd_val = '0;
    if (w == W_RMT_EN) rd_val = DW'(oth_en_i);
    if (w == W_RMT_ST) rd_val = DW'(oth_stat_i);
    if (w == W_LOC_EN) rd_val = DW'(en_q);
    if (w == W_LOC_ST) rd_val = DW'(stat_o);
    for (int n = 0; n < NCH; n++) begin
      if (w == n / 4) begin
        rd_val[8*(n%4)]   = !snd_i[n];
        rd_val[8*(n%4)+4] = snd_i[n];
      end
      if (w == W_FSTAT + n) rd_val = DW'(full_i[n]);
      if (w == W_MSTAT + n) rd_val = DW'(cnt_i[n]);
      if (w == W_DATA + n)  rd_val = (snd_i[n] || empty_i[n]) ? '0 : head_i[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q    <= '0;
      tx_q    <= '0;
      en_q    <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      // receive bit: set while receiving with data, cleared by W1C only when empty
      rx_q  <= (~snd_i & ~empty_i) | (rx_q & ~(clr & empty_i));
      tx_q  <= snd_i & ~full_i;
      if (req_i && we_i && (w == W_LOC_EN)) en_q <= wbits_i;
      if (req_i && !we_i) rdata_q <= rd_val;
      irq_q <= |(stat_o & en_q);
    end
  end

  assign en_o    = en_q;
  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  // R6: a receive bit whose buffer holds data survives the next edge
  p_rx_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(rx_q & ~empty_i) & ~rx_q) == '0));

  // R9: the interrupt line is only raised with some enable bit set
  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(en_q) != '0));
endmodule

// File: rtl/msg_box.sv
module msg_box
  import mbox_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_req,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_req,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam int SW = 2 * NCH;
  localparam int CW = $clog2(DEPTH + 1);

  logic          ureq [2];
  logic          uwe  [2];
  logic [AW-3:0] uwd  [2];
  logic [DW-1:0] uwdat[2];
  logic [DW-1:0] urd  [2];
  logic          uirq [2];
  logic [SW-1:0] stat [2];
  logic [SW-1:0] en   [2];
  logic [NCH-1:0] snd [2];

  // misaligned accesses are ignored
  assign ureq[0]  = a_req && (a_addr[1:0] == 2'b00);
  assign ureq[1]  = b_req && (b_addr[1:0] == 2'b00);
  assign uwe[0]   = a_we;
  assign uwe[1]   = b_we;
  assign uwd[0]   = a_addr[AW-1:2];
  assign uwd[1]   = b_addr[AW-1:2];
  assign uwdat[0] = a_wdata;
  assign uwdat[1] = b_wdata;

  // dir_q[n] = 1 : B sends on channel n
  logic [NCH-1:0] dir_q;
  assign snd[0] = ~dir_q;
  assign snd[1] = dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else begin
      // B first, A last, so A wins a same-cycle conflict
      for (int u = 1; u >= 0; u--) begin
        if (ureq[u] && uwe[u]) begin
          for (int n = 0; n < NCH; n++) begin
            if (int'(uwd[u]) == n / 4) begin
              if (uwdat[u][8*(n%4)+4])  dir_q[n] <= (u == 1);
              else if (uwdat[u][8*(n%4)]) dir_q[n] <= (u == 0);
            end
          end
        end
      end
    end
  end

  logic [NCH-1:0]          full, empty;
  logic [NCH-1:0][CW-1:0]  cnt;
  logic [NCH-1:0][DW-1:0]  head;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit_a, hit_b, push, pop;
    assign hit_a = ureq[0] && (int'(uwd[0]) == W_DATA + n);
    assign hit_b = ureq[1] && (int'(uwd[1]) == W_DATA + n);
    assign push  = dir_q[n] ? (hit_b && uwe[1])  : (hit_a && uwe[0]);
    assign pop   = dir_q[n] ? (hit_a && !uwe[0]) : (hit_b && !uwe[1]);

    mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .push_i  (push),
      .wdata_i (dir_q[n] ? uwdat[1] : uwdat[0]),
      .pop_i   (pop),
      .head_o  (head[n]),
      .count_o (cnt[n]),
      .full_o  (full[n]),
      .empty_o (empty[n])
    );
  end

  for (genvar u = 0; u < 2; u++) begin : g_user
    mbox_user #(.NCH(NCH), .DW(DW), .AW(AW), .CW(CW), .SW(SW)) u_user (
      .clk        (clk),
      .rst        (rst),
      .req_i      (ureq[u]),
      .we_i       (uwe[u]),
      .wd_i       (uwd[u]),
      .wbits_i    (uwdat[u][SW-1:0]),
      .snd_i      (snd[u]),
      .full_i     (full),
      .empty_i    (empty),
      .cnt_i      (cnt),
      .head_i     (head),
      .oth_stat_i (stat[1-u]),
      .oth_en_i   (en[1-u]),
      .stat_o     (stat[u]),
      .en_o       (en[u]),
      .rdata_o    (urd[u]),
      .irq_o      (uirq[u])
    );
  end

  assign a_rdata = urd[0];
  assign b_rdata = urd[1];
  assign a_irq   = uirq[0];
  assign b_irq   = uirq[1];

  // R7: a sender whose buffer is full loses its transmit bit one edge later
  p_tx_full_r7: assert property (@(posedge clk) disable iff (rst)
    (full[0] && !dir_q[0] && $stable(dir_q)) |=> !stat[0][1]);
endmodule

// File: tb/msg_box_bench.sv
`timescale 1ns/1ps
module msg_box_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [9:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;
  int          n_run = 0, n_fail = 0;
  logic [31:0] q, qa;

  always #2 clk = ~clk;

  msg_box u_msg_box (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input int u, input bit w, input int adr, input logic [31:0] d,
                    output logic [31:0] r);
    @(negedge clk);
    if (u == 0) begin a_req = 1; a_we = w; a_addr = 10'(adr); a_wdata = d; end
    else        begin b_req = 1; b_we = w; b_addr = 10'(adr); b_wdata = d; end
    @(negedge clk);
    a_req = 0; b_req = 0; a_we = 0; b_we = 0;
    r = (u == 0) ? a_rdata : b_rdata;
  endtask

  task automatic wr(input int u, input int adr, input logic [31:0] d);
    logic [31:0] dummy;
    op(u, 1'b1, adr, d, dummy);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [31:0] all_tx();
    logic [31:0] v = 0;
    for (int c = 0; c < 8; c++) v[2*c+1] = 1'b1;
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    idle(2);

    // R10 / R4: reset direction, enables, status, counts
    op(0, 0, 'h00, 0, q); chk("R10 A ctrl0", q, 32'h10101010);
    op(0, 0, 'h04, 0, q); chk("R10 A ctrl1", q, 32'h10101010);
    op(1, 0, 'h00, 0, q); chk("R4 B ctrl0", q, 32'h01010101);
    op(0, 0, 'h60, 0, q); chk("R10 A enable", q, 0);
    op(0, 0, 'h70, 0, q); chk("R10 A status", q, all_tx());
    op(1, 0, 'h70, 0, q); chk("R10 B status", q, 0);
    for (int c = 0; c < 8; c++) begin
      op(1, 0, 'h140 + 4*c, 0, q); chk("R10 count", q, 0);
    end

    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 5; i++) wr(0, 'h180 + 4*c, 32'hC0DE0000 + c*256 + i);
      idle(2);
      op(0, 0, 'h100 + 4*c, 0, q); chk("R2 full bit", q, 1);
      op(1, 0, 'h140 + 4*c, 0, q); chk("R2 count 4", q, 4);
      op(0, 0, 'h70, 0, q);  chk("R7 tx clear when full", q, all_tx() & ~(32'd1 << (2*c+1)));
      op(1, 0, 'h70, 0, q);  chk("R5 rx set", q, 32'd1 << (2*c));
      op(0, 0, 'h50, 0, q);  chk("R8 remote status", q, 32'd1 << (2*c));
      wr(1, 'h70, 32'd1 << (2*c)); idle(1);
      op(1, 0, 'h70, 0, q);  chk("R6 clear ignored", q, 32'd1 << (2*c));
      op(0, 0, 'h180 + 4*c, 0, q); chk("R3 sender read zero", q, 0);
      wr(1, 'h180 + 4*c, 32'hDEADBEEF);
      op(1, 0, 'h140 + 4*c, 0, q); chk("R3 no change", q, 4);
      for (int i = 0; i < 4; i++) begin
        op(1, 0, 'h180 + 4*c, 0, q); chk("R1 fifo order", q, 32'hC0DE0000 + c*256 + i);
      end
      op(1, 0, 'h180 + 4*c, 0, q); chk("R3 empty pop zero", q, 0);
      op(1, 0, 'h140 + 4*c, 0, q); chk("R3 count zero", q, 0);
      wr(1, 'h70, 32'd1 << (2*c)); idle(2);
      op(1, 0, 'h70, 0, q); chk("R6 clear when empty", q, 0);
      op(0, 0, 'h50, 0, q); chk("R8 ack seen", q, 0);
      op(0, 0, 'h70, 0, q); chk("R7 tx back", q, all_tx());
    end

    // R4: B takes channel 6 as sender
    wr(1, 'h04, 32'h00100000); idle(1);
    op(0, 0, 'h04, 0, q); chk("R4 A ctrl1 after flip", q, 32'h10011010);
    op(1, 0, 'h04, 0, q); chk("R4 B ctrl1 after flip", q, 32'h01100101);
    wr(0, 'h04, 32'h0); idle(1);
    op(1, 0, 'h04, 0, q); chk("R4 neither bit", q, 32'h01100101);

    // R9 / R8: interrupt on A for channel 6 receive
    wr(0, 'h60, 32'd1 << 12);
    wr(1, 'h180 + 24, 32'h11);
    wr(1, 'h180 + 24, 32'h22);
    idle(3);
    chk("R9 A irq high", {31'd0, a_irq}, 1);
    chk("R9 B irq low", {31'd0, b_irq}, 0);
    op(1, 0, 'h40, 0, q); chk("R8 remote enable", q, 32'd1 << 12);
    wr(1, 'h40, 32'hFFFF); idle(1);
    op(0, 0, 'h60, 0, q); chk("R8 remote enable read only", q, 32'd1 << 12);
    op(0, 0, 'h70, 0, q); chk("R7 A not sender", q, all_tx() & ~(32'd1 << 13) | (32'd1 << 12));

    // R1: A pops and B pushes in the same cycle
    op(0, 0, 'h180 + 24, 0, q); chk("R1 pop 1", q, 32'h11);
    @(negedge clk);
    a_req = 1; a_we = 0; a_addr = 10'('h180 + 24);
    b_req = 1; b_we = 1; b_addr = 10'('h180 + 24); b_wdata = 32'h33;
    @(negedge clk);
    a_req = 0; b_req = 0; b_we = 0;
    qa = a_rdata; chk("R1 pop during push", qa, 32'h22);
    op(1, 0, 'h140 + 24, 0, q); chk("R2 count after both", q, 1);
    op(0, 0, 'h180 + 24, 0, q); chk("R1 pop 3", q, 32'h33);
    wr(0, 'h70, 32'd1 << 12); idle(3);
    chk("R9 A irq low", {31'd0, a_irq}, 0);

    // R4: A reclaims channel 6
    wr(0, 'h04, 32'h00100000); idle(1);
    op(1, 0, 'h04, 0, q); chk("R4 B ctrl1 restored", q, 32'h01010101);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule